// File: doc/BRIEF.md
# Programmable Tapped Delay Line

This block delays a single-bit signal by a number of clock cycles chosen at run time. The delay is a fixed base latency plus a 4-bit code times a fixed per-step increment, both given in cycles at elaboration. The signal travels through a shift register, and the output is read from the tap that the code selects. The code is not captured: the selected tap follows the code lines within the same cycle. A disable input forces the output low.

Changing the code or releasing the disable at the wrong moment makes the output untrustworthy. The block watches for three misuses and raises a sticky flag, which only reset clears:
- the code is raised too soon after the delayed signal last changed;
- the disable is released before the line has been held clear long enough;
- an input pulse is too short for the programmed delay.

Top module: `prog_delay_line`

## Requirements
- R1: With D = BASE + code×STEP (defaults BASE=1, STEP=1), the level of sig_in sampled at rising edge k is driven on sig_out from rising edge k+D−1 until the next edge. A larger code always gives a longer delay.
- R2: tap_sel is not registered. A new code selects its tap in the same cycle, so right after the change sig_out shows the level sampled D_new−1 edges earlier.
- R3: While out_off is 1, sig_out is 0. While out_off is 0, sig_out is the delayed signal.
- R4: The delayed signal is the selected tap, with out_off ignored. Suppose an edge samples tap_sel N codes higher than the previous edge did. If fewer than N×STEP edges have passed after the first edge that sampled the last level change of the delayed signal (the code being unchanged at that time), rule_viol goes to 1 after that edge.
- R5: A code sampled lower than at the previous edge never sets rule_viol by itself.
- R6: A release is an edge that samples out_off 0 after the previous edge sampled 1. Count the consecutive edges just before the release that sampled out_off 1 and sig_in 0. If that count is below code×STEP, rule_viol goes to 1 after the release edge. Code 0 needs no hold.
- R7: A high pulse of sig_in lasting W sampled edges, with 5×W < D, sets rule_viol after the edge that samples sig_in back at 0.
- R8: Once set, rule_viol stays 1 until reset. Reset (rst_n low, asynchronous) clears it.
- R9: During reset and afterwards, until data has travelled through the line, sig_out is 0 whatever sig_in does. The line resets to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Signal to be delayed |
| tap_sel | input | 4 | Delay code, not latched |
| out_off | input | 1 | Active-high output disable |
| sig_out | output | 1 | Delayed signal, low while disabled |
| rule_viol | output | 1 | Sticky timing-rule violation flag |

## Verification
The hold-off rule (R4) is the hardest case to reach from the ports. It needs a known edge on the delayed signal, followed by a code increase landing exactly one edge short of, or exactly on, the required distance. The bench gets there by running at code 0, where the output edge follows the input edge by a single cycle. It ends a pulse at a known falling edge and then raises the code to 3 after a counted number of cycles. The clear and pulse-width rules are probed the same way, one cycle either side of their thresholds.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
    localparam int CODE_W    = 4;
    localparam int NUM_CODES = 1 << CODE_W;
    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/tdl_shift_line.sv
module tdl_shift_line
    import tdl_pkg::*;
#(
    parameter int BASE = 1,
    parameter int STEP = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  din,
    input  code_t code,
    output logic  tap
);
    localparam int DEPTH = BASE + (NUM_CODES - 1) * STEP;

    typedef struct packed {
        logic [DEPTH-1:0] line;
    } line_state_t;

    line_state_t state_d, state_q;
    logic [NUM_CODES-1:0] taps;

    always_comb begin
        state_d      = state_q;
        state_d.line = {state_q.line[DEPTH-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // One fixed tap per code; a larger code always sits deeper in the line.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tap
        assign taps[g] = state_q.line[BASE + g * STEP - 1];
    end

    assign tap = taps[code];

    // R1: the first stage always holds the previous sample of the input
    assert_line_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> state_q.line[0] == $past(din));
endmodule

// File: rtl/tdl_rule_monitor.sv
module tdl_rule_monitor
    import tdl_pkg::*;
#(
    parameter int BASE = 1,
    parameter int STEP = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  din,
    input  code_t code,
    input  logic  off,
    input  logic  tap,
    output logic  viol
);
    localparam int DEPTH = BASE + (NUM_CODES - 1) * STEP;
    localparam int CNT_W = $clog2(DEPTH + 2);
    localparam int MUL_W = CNT_W + 3;

    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t STEP_C = cnt_t'(STEP);
    localparam cnt_t BASE_C = cnt_t'(BASE);
    localparam cnt_t SAT    = '1;

    typedef struct packed {
        code_t code_prev;
        logic  tap_prev;
        logic  off_prev;
        logic  din_prev;
        cnt_t  since;
        cnt_t  clear;
        cnt_t  high;
        logic  viol;
    } mon_state_t;

    mon_state_t state_d, state_q;

    cnt_t code_w, prev_w, hold_need, clear_need, total;
    logic hold_bad, clear_bad, pulse_bad, tap_edge;

    function automatic cnt_t sat_inc(input cnt_t x);
        return (x == SAT) ? x : x + cnt_t'(1);
    endfunction

    assign code_w     = cnt_t'(code);
    assign prev_w     = cnt_t'(state_q.code_prev);
    assign hold_need  = (code_w - prev_w) * STEP_C;
    assign clear_need = code_w * STEP_C;
    assign total      = BASE_C + clear_need;
    assign tap_edge   = (tap != state_q.tap_prev) && (code == state_q.code_prev);

    always_comb begin
        hold_bad  = (code_w > prev_w) && (state_q.since < hold_need);
        clear_bad = state_q.off_prev && !off && (state_q.clear < clear_need);
        pulse_bad = state_q.din_prev && !din &&
                    ((MUL_W'(state_q.high) * MUL_W'(5)) < MUL_W'(total));

        state_d           = state_q;
        state_d.code_prev = code;
        state_d.tap_prev  = tap;
        state_d.off_prev  = off;
        state_d.din_prev  = din;
        state_d.since     = tap_edge ? cnt_t'(1) : sat_inc(state_q.since);
        state_d.clear     = (off && !din) ? sat_inc(state_q.clear) : '0;
        state_d.high      = din ? sat_inc(state_q.high) : '0;
        state_d.viol      = state_q.viol | hold_bad | clear_bad | pulse_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.since <= SAT;
        end else begin
            state_q <= state_d;
        end
    end

    assign viol = state_q.viol;

    // R8: the flag never drops without reset
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.viol |=> state_q.viol);

    // R5: a lowered code, with no release and no pulse end, leaves a clear flag clear
    assert_down_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code < $past(code)) && !($past(off) && !off) && !($past(din) && !din)
        && !state_q.viol |=> !state_q.viol);
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
    import tdl_pkg::*;
#(
    parameter int BASE = 1,
    parameter int STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic [CODE_W-1:0] tap_sel,
    input  logic              out_off,
    output logic              sig_out,
    output logic              rule_viol
);
    logic tap;

    tdl_shift_line #(.BASE(BASE), .STEP(STEP)) u_line (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sig_in),
        .code (tap_sel),
        .tap  (tap)
    );

    tdl_rule_monitor #(.BASE(BASE), .STEP(STEP)) u_mon (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sig_in),
        .code (tap_sel),
        .off  (out_off),
        .tap  (tap),
        .viol (rule_viol)
    );

    assign sig_out = tap & ~out_off;

    // R3: a disabled output is low at every sampled edge
    assert_off_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_off |-> !sig_out);
endmodule

// File: tb/prog_delay_line_tb.sv
module prog_delay_line_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sig_in = 1'b0;
    logic [3:0] tap_sel = 4'd0;
    logic       out_off = 1'b0;
    logic       sig_out;
    logic       rule_viol;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prog_delay_line u_dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tap_sel(tap_sel),
        .out_off(out_off), .sig_out(sig_out), .rule_viol(rule_viol)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int code);
        rst_n = 1'b0; sig_in = 1'b0; out_off = 1'b0; tap_sel = 4'(code);
        tick(3);
        rst_n = 1'b1;
    endtask

    function automatic bit pat(input int i, input int c);
        return ((i * 37 + c * 11) % 7) > 3;
    endfunction

    task automatic t_reset_R9();
        rst_n = 1'b0; tap_sel = 4'd0; out_off = 1'b0; sig_in = 1'b1;
        tick(3);
        chk(sig_out == 1'b0, "R9 out in reset", int'(sig_out), 0);
        chk(rule_viol == 1'b0, "R9 flag in reset", int'(rule_viol), 0);
        sig_in = 1'b0;
        rst_n = 1'b1;
        tick(1);
        chk(sig_out == 1'b0, "R9 out after reset", int'(sig_out), 0);
        chk(rule_viol == 1'b0, "R9 flag after reset", int'(rule_viol), 0);
    endtask

    task automatic t_delay_R1();
        for (int c = 0; c < 16; c++) begin
            int d = 1 + c;
            bit v [0:63];
            do_reset(c);
            for (int i = 0; i < 40; i++) begin
                bit e;
                tick(1);
                v[i] = pat(i, c);
                sig_in = v[i];
                #1;
                e = (i >= d) ? v[i-d] : 1'b0;
                chk(sig_out == e, $sformatf("R1 code=%0d i=%0d", c, i), int'(sig_out), int'(e));
            end
        end
    endtask

    task automatic t_direct_R2();
        bit v [0:63];
        do_reset(2);
        for (int i = 0; i < 30; i++) begin
            tick(1);
            v[i] = pat(i, 5);
            sig_in = v[i];
        end
        tick(1);
        tap_sel = 4'd9;
        #1;
        chk(sig_out == v[30-10], "R2 same-cycle tap", int'(sig_out), int'(v[20]));
        tap_sel = 4'd0;
        #1;
        chk(sig_out == v[29], "R2 back to code 0", int'(sig_out), int'(v[29]));
    endtask

    task automatic t_off_R3();
        bit v [0:63];
        do_reset(1);
        for (int i = 0; i < 25; i++) begin
            bit e;
            tick(1);
            v[i] = pat(i, 3);
            sig_in = v[i];
            out_off = (i >= 10 && i < 15);
            #1;
            e = out_off ? 1'b0 : ((i >= 2) ? v[i-2] : 1'b0);
            chk(sig_out == e, $sformatf("R3 i=%0d", i), int'(sig_out), int'(e));
        end
        out_off = 1'b0;
    endtask

    task automatic t_hold_R4(input int k, input bit exp);
        do_reset(0);
        tick(1); sig_in = 1'b1;
        tick(4); sig_in = 1'b0;
        tick(k); tap_sel = 4'd3;
        tick(1);
        chk(rule_viol == exp, $sformatf("R4 raise after %0d", k), int'(rule_viol), int'(exp));
        tick(3);
        chk(rule_viol == exp, $sformatf("R4 later %0d", k), int'(rule_viol), int'(exp));
    endtask

    task automatic t_down_R5();
        do_reset(15);
        tick(1); sig_in = 1'b1;
        tick(4); sig_in = 1'b0;
        tick(1); tap_sel = 4'd0;
        tick(1);
        chk(rule_viol == 1'b0, "R5 lower code", int'(rule_viol), 0);
        tick(20);
        chk(rule_viol == 1'b0, "R5 lower code later", int'(rule_viol), 0);
    endtask

    task automatic t_clear_R6(input int code, input int h, input bit exp);
        do_reset(code);
        tick(1); out_off = 1'b1;
        tick(h); out_off = 1'b0;
        tick(1);
        chk(rule_viol == exp, $sformatf("R6 code=%0d hold=%0d", code, h), int'(rule_viol), int'(exp));
    endtask

    task automatic t_pulse_R7(input int code, input int w, input bit exp);
        do_reset(code);
        tick(1); sig_in = 1'b1;
        tick(w); sig_in = 1'b0;
        tick(1);
        chk(rule_viol == exp, $sformatf("R7 code=%0d width=%0d", code, w), int'(rule_viol), int'(exp));
    endtask

    task automatic t_sticky_R8();
        do_reset(15);
        tick(1); sig_in = 1'b1;
        tick(1); sig_in = 1'b0;
        tick(1);
        chk(rule_viol == 1'b1, "R8 set", int'(rule_viol), 1);
        tick(30);
        chk(rule_viol == 1'b1, "R8 held", int'(rule_viol), 1);
        do_reset(0);
        chk(rule_viol == 1'b0, "R8 cleared by reset", int'(rule_viol), 0);
    endtask

    initial begin
        tick(1);
        t_reset_R9();
        t_delay_R1();
        t_direct_R2();
        t_off_R3();
        t_hold_R4(3, 1'b1);
        t_hold_R4(4, 1'b0);
        t_down_R5();
        t_clear_R6(5, 4, 1'b1);
        t_clear_R6(5, 5, 1'b0);
        t_clear_R6(0, 1, 1'b0);
        t_pulse_R7(15, 3, 1'b1);
        t_pulse_R7(15, 4, 1'b0);
        t_pulse_R7(0, 1, 1'b0);
        t_sticky_R8();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule